// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block brings a combined USB2/USB3 PHY and its controller from full reset to an operating state in a fixed order. A one-cycle start pulse launches the sequence. The sequence first puts every reset back into the asserted state and selects the reference clock source. It then takes the USB2 PHY out of IDDQ and releases the USB3 test power-down. Next it releases the two PHY resets and waits. After the wait it raises the power-good indications and turns on spread-spectrum clocking, then releases the controller resets and waits again. It then forces the VBUS-valid indications and waits a third time. Every wait lasts a parameter number of cycles, so the same design can be sized for a 100 µs settle time at any clock rate.

The last step is a read-modify-write of a PHY-internal register over an external control-register bus. The block reads the register, retrying only on a timeout response. It then writes back the value read, with an enable bit and a transmit-boost level ORed in. Success raises `ready_o`. Running out of read attempts, or a write that times out, raises `error_o` and stops the sequence. While in either end state, a stop pulse shuts the PHY down.

Requests leave on a valid/ready channel. A request stays valid, with its fields unchanged, until the bus accepts it, so the bus can apply back-pressure by holding `req_ready_i` low. The response side has no ready signal. The block accepts a response in the cycle `rsp_valid_i` is high, and only while it is waiting for one.

Top module: `usbphy_pwrup_seq`

## Requirements
- R1: After reset, all four resets are asserted (ctrl_rst_n_o, aux_rst_n_o, u3phy_rst_n_o and u2por_n_o are all 0). u2_iddq_o and u3_testpd_o are 1. The power-good, spread-spectrum and VBUS outputs, refclk_en_o, ready_o, error_o and req_valid_o are all 0.
- R2: A start pulse accepted in the idle state first puts every output back to its R1 value, with all four resets asserted. One cycle later it sets refclk_en_o. In that same cycle refclk_pad_o takes the value of clk_src_pad_i (1 = pad source, 0 = internal source).
- R3: After the clock step, u2_iddq_o falls one cycle later. u3_testpd_o falls one cycle after that. One cycle after that, u3phy_rst_n_o and u2por_n_o rise together.
- R4: Exactly WAIT_CYCLES cycles after the PHY resets are released, ana_pwr_en_o, pcs_pwr_ok_o and pma_pwr_ok_o rise in the same cycle.
- R5: After power-good, ssc_en_o rises first. Then ctrl_rst_n_o and aux_rst_n_o rise together. Exactly WAIT_CYCLES cycles later, all four VBUS outputs rise together.
- R6: Exactly WAIT_CYCLES cycles after the VBUS outputs rise, a read request (req_write_o = 0) is raised with req_addr_o = 0x000F. A response with rsp_timeout_i = 1 triggers a new read request. After RD_TRIES (3) timed-out reads, error_o rises, no write is issued, and ready_o stays 0.
- R7: After a read that does not time out, a single write request to 0x000F is issued. Its data is the read data ORed with bit 9 and with BOOST_LVL (default 5) shifted left by 6, so the default mask is 0x0340. A write response without timeout raises ready_o. A write timeout raises error_o instead. ready_o and error_o are never high together.
- R8: While req_valid_o is 1 and req_ready_i is 0, req_valid_o stays 1 in the next cycle and req_write_o, req_addr_o and req_wdata_o do not change.
- R9: A stop pulse in the ready or error state does the following one cycle later: u3phy_rst_n_o and u2por_n_o go to 0, refclk_en_o goes to 0, and ready_o and error_o go to 0. All other outputs keep their values.
- R10: A start or stop pulse received while the sequence is running is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Shutdown pulse |
| clk_src_pad_i | input | 1 | Reference source select: 1 pad, 0 internal |
| req_valid_o | output | 1 | Register-bus request valid |
| req_ready_i | input | 1 | Register-bus request accepted |
| req_write_o | output | 1 | 1 write, 0 read |
| req_addr_o | output | ADDR_W | PHY register address |
| req_wdata_o | output | DATA_W | Write data |
| rsp_valid_i | input | 1 | Response strobe |
| rsp_timeout_i | input | 1 | Response is a timeout |
| rsp_rdata_i | input | DATA_W | Read data |
| ctrl_rst_n_o | output | 1 | Controller reset, active low |
| aux_rst_n_o | output | 1 | Auxiliary reset, active low |
| u3phy_rst_n_o | output | 1 | USB3 PHY reset, active low |
| u2por_n_o | output | 1 | USB2 PHY power-on reset, active low |
| refclk_en_o | output | 1 | Reference clock enable |
| refclk_pad_o | output | 1 | Reference source: 1 pad, 0 internal |
| u2_iddq_o | output | 1 | USB2 PHY IDDQ mode |
| u3_testpd_o | output | 1 | USB3 PHY test power-down |
| ana_pwr_en_o | output | 1 | Analog power enable |
| pcs_pwr_ok_o | output | 1 | PCS power stable |
| pma_pwr_ok_o | output | 1 | PMA power stable |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| u3_vbus_valid_o | output | 1 | USB3 VBUS-valid override value |
| u3_vbus_sel_o | output | 1 | USB3 VBUS-valid override select |
| u2_vbus_valid_o | output | 1 | USB2 VBUS-valid override value |
| u2_vbus_sel_o | output | 1 | USB2 VBUS-valid override select |
| ready_o | output | 1 | Sequence completed |
| error_o | output | 1 | Sequence failed |

## Verification
The assertions check the structural ordering on every cycle:
- a released USB3 PHY reset implies that IDDQ and test power-down are off and the clock is on;
- a released controller reset implies that power-good and spread-spectrum are on;
- a VBUS override implies that the controller reset is released;
- the request channel holds steady under back-pressure, always targets the boost register, and writes always carry the enable and boost mask;
- ready and error are mutually exclusive.

Only the bench scenarios can show the exact wait lengths and the one-cycle step spacing. They also show how many read attempts are made for each number of injected timeouts, that the written value equals the read value with the mask added, which clock source was selected, and that stray start and stop pulses leave a running sequence untouched.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CLKSEL, S_IDDQ, S_TPD, S_PHYREL, S_WAIT1, S_SSC,
    S_CREL, S_WAIT2, S_WAIT3, S_RMW, S_DONE, S_ERR
  } step_e;

  typedef enum logic [2:0] {
    R_IDLE, R_RD_REQ, R_RD_RSP, R_WR_REQ, R_WR_RSP
  } rmw_e;

  typedef struct packed {
    logic ctrl_rst_n;
    logic aux_rst_n;
    logic u3phy_rst_n;
    logic u2por_n;
    logic refclk_en;
    logic refclk_pad;
    logic u2_iddq;
    logic u3_testpd;
    logic pwr_good;
    logic ssc_en;
    logic vbus_ovr;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{
    ctrl_rst_n: 1'b0, aux_rst_n: 1'b0, u3phy_rst_n: 1'b0, u2por_n: 1'b0,
    refclk_en: 1'b0, refclk_pad: 1'b0, u2_iddq: 1'b1, u3_testpd: 1'b1,
    pwr_good: 1'b0, ssc_en: 1'b0, vbus_ovr: 1'b0
  };

endpackage

// File: rtl/usbphy_wait_timer.sv
module usbphy_wait_timer #(
  parameter int unsigned CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic expired_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start_i) begin
      cnt  <= CW'(CYCLES - 1);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - CW'(1);
    end
  end

  assign expired_o = busy && (cnt == '0);

endmodule

// File: rtl/usbphy_rmw_engine.sv
module usbphy_rmw_engine
  import usbphy_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_ADDR  = 'hF,
  parameter int unsigned RD_TRIES  = 3,
  parameter int unsigned EN_BIT    = 9,
  parameter int unsigned LVL_POS   = 6,
  parameter int unsigned LVL_W     = 3,
  parameter int unsigned BOOST_LVL = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_timeout_i,
  input  logic [DATA_W-1:0] rsp_rdata_i
);
  localparam int unsigned TW = $clog2(RD_TRIES + 1);
  localparam int unsigned LVL_MAX = (1 << LVL_W);
  localparam logic [DATA_W-1:0] SET_MASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(BOOST_LVL % LVL_MAX) << LVL_POS);

  rmw_e              st;
  logic [TW-1:0]     tries;
  logic [DATA_W-1:0] wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= R_IDLE;
      tries  <= '0;
      wdata  <= '0;
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      case (st)
        R_IDLE: if (go_i) begin
          tries <= '0;
          st    <= R_RD_REQ;
        end
        R_RD_REQ: if (req_ready_i) st <= R_RD_RSP;
        R_RD_RSP: if (rsp_valid_i) begin
          if (rsp_timeout_i) begin
            if (tries == TW'(RD_TRIES - 1)) begin
              fail_o <= 1'b1;
              st     <= R_IDLE;
            end else begin
              tries <= tries + TW'(1);
              st    <= R_RD_REQ;
            end
          end else begin
            wdata <= rsp_rdata_i | SET_MASK;
            st    <= R_WR_REQ;
          end
        end
        R_WR_REQ: if (req_ready_i) st <= R_WR_RSP;
        R_WR_RSP: if (rsp_valid_i) begin
          if (rsp_timeout_i) fail_o <= 1'b1;
          else               done_o <= 1'b1;
          st <= R_IDLE;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st == R_RD_REQ) || (st == R_WR_REQ);
  assign req_write_o = (st == R_WR_REQ);
  assign req_addr_o  = ADDR_W'(REG_ADDR);
  assign req_wdata_o = req_write_o ? wdata : '0;

endmodule

// File: rtl/usbphy_step_ctrl.sv
module usbphy_step_ctrl
  import usbphy_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic pad_sel_i,
  input  logic tmr_exp_i,
  input  logic rmw_done_i,
  input  logic rmw_fail_i,
  output logic tmr_start_o,
  output logic rmw_go_o,
  output ctl_t ctl_o,
  output logic ready_o,
  output logic error_o
);
  step_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctl_o   <= CTL_IDLE;
      ready_o <= 1'b0;
      error_o <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          ctl_o <= CTL_IDLE;
          st    <= S_CLKSEL;
        end
        S_CLKSEL: begin
          ctl_o.refclk_en  <= 1'b1;
          ctl_o.refclk_pad <= pad_sel_i;
          st               <= S_IDDQ;
        end
        S_IDDQ: begin
          ctl_o.u2_iddq <= 1'b0;
          st            <= S_TPD;
        end
        S_TPD: begin
          ctl_o.u3_testpd <= 1'b0;
          st              <= S_PHYREL;
        end
        S_PHYREL: begin
          ctl_o.u3phy_rst_n <= 1'b1;
          ctl_o.u2por_n     <= 1'b1;
          st                <= S_WAIT1;
        end
        S_WAIT1: if (tmr_exp_i) begin
          ctl_o.pwr_good <= 1'b1;
          st             <= S_SSC;
        end
        S_SSC: begin
          ctl_o.ssc_en <= 1'b1;
          st           <= S_CREL;
        end
        S_CREL: begin
          ctl_o.ctrl_rst_n <= 1'b1;
          ctl_o.aux_rst_n  <= 1'b1;
          st               <= S_WAIT2;
        end
        S_WAIT2: if (tmr_exp_i) begin
          ctl_o.vbus_ovr <= 1'b1;
          st             <= S_WAIT3;
        end
        S_WAIT3: if (tmr_exp_i) st <= S_RMW;
        S_RMW: begin
          if (rmw_done_i) begin
            ready_o <= 1'b1;
            st      <= S_DONE;
          end else if (rmw_fail_i) begin
            error_o <= 1'b1;
            st      <= S_ERR;
          end
        end
        S_DONE, S_ERR: if (stop_i) begin
          ctl_o.u3phy_rst_n <= 1'b0;
          ctl_o.u2por_n     <= 1'b0;
          ctl_o.refclk_en   <= 1'b0;
          ready_o           <= 1'b0;
          error_o           <= 1'b0;
          st                <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tmr_start_o = (st == S_PHYREL) || (st == S_CREL) ||
                       ((st == S_WAIT2) && tmr_exp_i);
  assign rmw_go_o    = (st == S_WAIT3) && tmr_exp_i;

endmodule

// File: rtl/usbphy_pwrup_seq.sv
module usbphy_pwrup_seq
  import usbphy_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned WAIT_CYCLES = 20000,
  parameter int unsigned REG_ADDR    = 'hF,
  parameter int unsigned RD_TRIES    = 3,
  parameter int unsigned EN_BIT      = 9,
  parameter int unsigned LVL_POS     = 6,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned BOOST_LVL   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              clk_src_pad_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_timeout_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              ctrl_rst_n_o,
  output logic              aux_rst_n_o,
  output logic              u3phy_rst_n_o,
  output logic              u2por_n_o,
  output logic              refclk_en_o,
  output logic              refclk_pad_o,
  output logic              u2_iddq_o,
  output logic              u3_testpd_o,
  output logic              ana_pwr_en_o,
  output logic              pcs_pwr_ok_o,
  output logic              pma_pwr_ok_o,
  output logic              ssc_en_o,
  output logic              u3_vbus_valid_o,
  output logic              u3_vbus_sel_o,
  output logic              u2_vbus_valid_o,
  output logic              u2_vbus_sel_o,
  output logic              ready_o,
  output logic              error_o
);
  ctl_t ctl;
  logic tmr_start, tmr_exp, rmw_go, rmw_done, rmw_fail;

  usbphy_step_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .pad_sel_i  (clk_src_pad_i),
    .tmr_exp_i  (tmr_exp),
    .rmw_done_i (rmw_done),
    .rmw_fail_i (rmw_fail),
    .tmr_start_o(tmr_start),
    .rmw_go_o   (rmw_go),
    .ctl_o      (ctl),
    .ready_o    (ready_o),
    .error_o    (error_o)
  );

  usbphy_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (tmr_start),
    .expired_o(tmr_exp)
  );

  usbphy_rmw_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .RD_TRIES(RD_TRIES), .EN_BIT(EN_BIT), .LVL_POS(LVL_POS),
    .LVL_W(LVL_W), .BOOST_LVL(BOOST_LVL)
  ) u_rmw (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (rmw_go),
    .done_o       (rmw_done),
    .fail_o       (rmw_fail),
    .req_valid_o  (req_valid_o),
    .req_ready_i  (req_ready_i),
    .req_write_o  (req_write_o),
    .req_addr_o   (req_addr_o),
    .req_wdata_o  (req_wdata_o),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_timeout_i(rsp_timeout_i),
    .rsp_rdata_i  (rsp_rdata_i)
  );

  assign ctrl_rst_n_o    = ctl.ctrl_rst_n;
  assign aux_rst_n_o     = ctl.aux_rst_n;
  assign u3phy_rst_n_o   = ctl.u3phy_rst_n;
  assign u2por_n_o       = ctl.u2por_n;
  assign refclk_en_o     = ctl.refclk_en;
  assign refclk_pad_o    = ctl.refclk_pad;
  assign u2_iddq_o       = ctl.u2_iddq;
  assign u3_testpd_o     = ctl.u3_testpd;
  assign ana_pwr_en_o    = ctl.pwr_good;
  assign pcs_pwr_ok_o    = ctl.pwr_good;
  assign pma_pwr_ok_o    = ctl.pwr_good;
  assign ssc_en_o        = ctl.ssc_en;
  assign u3_vbus_valid_o = ctl.vbus_ovr;
  assign u3_vbus_sel_o   = ctl.vbus_ovr;
  assign u2_vbus_valid_o = ctl.vbus_ovr;
  assign u2_vbus_sel_o   = ctl.vbus_ovr;

endmodule

// File: rtl/usbphy_pwrup_seq_chk.sv
module usbphy_pwrup_seq_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_ADDR  = 'hF,
  parameter int unsigned EN_BIT    = 9,
  parameter int unsigned LVL_POS   = 6,
  parameter int unsigned LVL_W     = 3,
  parameter int unsigned BOOST_LVL = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_write_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o,
  input logic              ctrl_rst_n_o,
  input logic              aux_rst_n_o,
  input logic              u3phy_rst_n_o,
  input logic              u2por_n_o,
  input logic              refclk_en_o,
  input logic              u2_iddq_o,
  input logic              u3_testpd_o,
  input logic              ana_pwr_en_o,
  input logic              ssc_en_o,
  input logic              u3_vbus_valid_o,
  input logic              ready_o,
  input logic              error_o
);
  localparam int unsigned LVL_MAX = (1 << LVL_W);
  localparam logic [DATA_W-1:0] MASK =
    (DATA_W'(1) << EN_BIT) | (DATA_W'(BOOST_LVL % LVL_MAX) << LVL_POS);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_write_o) &&
    $stable(req_addr_o) && $stable(req_wdata_o));

  // R6
  req_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> req_addr_o == ADDR_W'(REG_ADDR));

  // R7
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && req_write_o |-> (req_wdata_o & MASK) == MASK);

  // R2
  clk_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refclk_en_o) |-> !ctrl_rst_n_o && !aux_rst_n_o &&
    !u3phy_rst_n_o && !u2por_n_o);

  // R3
  phy_rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u3phy_rst_n_o |-> !u2_iddq_o && !u3_testpd_o && refclk_en_o);

  // R5
  ctrl_rel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst_n_o |-> ana_pwr_en_o && ssc_en_o);

  // R5
  vbus_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    u3_vbus_valid_o |-> ctrl_rst_n_o);

  // R7
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && error_o));

  // R9
  shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> !refclk_en_o && !u3phy_rst_n_o && !u2por_n_o);

endmodule

bind usbphy_pwrup_seq usbphy_pwrup_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR), .EN_BIT(EN_BIT),
  .LVL_POS(LVL_POS), .LVL_W(LVL_W), .BOOST_LVL(BOOST_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i), .req_write_o(req_write_o),
  .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
  .ctrl_rst_n_o(ctrl_rst_n_o), .aux_rst_n_o(aux_rst_n_o),
  .u3phy_rst_n_o(u3phy_rst_n_o), .u2por_n_o(u2por_n_o),
  .refclk_en_o(refclk_en_o), .u2_iddq_o(u2_iddq_o),
  .u3_testpd_o(u3_testpd_o), .ana_pwr_en_o(ana_pwr_en_o),
  .ssc_en_o(ssc_en_o), .u3_vbus_valid_o(u3_vbus_valid_o),
  .ready_o(ready_o), .error_o(error_o)
);

// File: tb/usbphy_pwrup_seq_tb.sv
`timescale 1ns/1ps
module usbphy_pwrup_seq_tb;
  localparam int W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, start_i = 1'b0, stop_i = 1'b0, clk_src_pad_i = 1'b0;
  logic        req_valid_o, req_ready_i = 1'b0, req_write_o;
  logic [15:0] req_addr_o, req_wdata_o;
  logic        rsp_valid_i = 1'b0, rsp_timeout_i = 1'b0;
  logic [15:0] rsp_rdata_i = '0;
  logic ctrl_rst_n_o, aux_rst_n_o, u3phy_rst_n_o, u2por_n_o, refclk_en_o, refclk_pad_o;
  logic u2_iddq_o, u3_testpd_o, ana_pwr_en_o, pcs_pwr_ok_o, pma_pwr_ok_o, ssc_en_o;
  logic u3_vbus_valid_o, u3_vbus_sel_o, u2_vbus_valid_o, u2_vbus_sel_o, ready_o, error_o;

  usbphy_pwrup_seq #(.WAIT_CYCLES(W)) u_dut (.*);

  int errors = 0, checks = 0, cyc = 0;

  // responder / monitor state
  int rd_tmo_left = 0; bit wr_tmo_cfg = 0; logic [15:0] rd_val = '0;
  int n_rd = 0, n_wr = 0; logic [15:0] wr_seen = '0, addr_seen = '0;
  bit hs = 0, hs_wr = 0, pend = 0, pend_wr = 0; int lat = 0;
  bit arm = 0;
  int t_crst, t_clk, t_iddq, t_tpd, t_u3, t_u2, t_ana, t_pcs, t_pma;
  int t_ssc, t_crel, t_aux, t_vb3, t_vb2, t_req;

  function automatic logic [15:0] exp_wdata(logic [15:0] v);
    return v | 16'h0200 | (16'(5) << 6);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    if (req_valid_o && req_ready_i) begin
      hs = 1; hs_wr = req_write_o; addr_seen = req_addr_o;
      if (req_write_o) begin n_wr++; wr_seen = req_wdata_o; end
      else n_rd++;
    end
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    rsp_valid_i = 0; rsp_timeout_i = 0;
    req_ready_i = ($urandom % 3) != 0;
    if (pend) begin
      if (lat == 0) begin
        rsp_valid_i = 1; pend = 0;
        if (pend_wr) rsp_timeout_i = wr_tmo_cfg;
        else if (rd_tmo_left > 0) begin rsp_timeout_i = 1; rd_tmo_left--; end
        else rsp_rdata_i = rd_val;
      end else lat--;
    end
    if (hs) begin hs = 0; pend = 1; pend_wr = hs_wr; lat = $urandom % 3; end
    if (arm) begin
      if (t_crst < 0 && !ctrl_rst_n_o) t_crst = cyc;
      if (t_clk < 0 && refclk_en_o) t_clk = cyc;
      if (t_clk >= 0) begin
        if (t_iddq < 0 && !u2_iddq_o) t_iddq = cyc;
        if (t_tpd < 0 && !u3_testpd_o) t_tpd = cyc;
        if (t_u3 < 0 && u3phy_rst_n_o) t_u3 = cyc;
        if (t_u2 < 0 && u2por_n_o) t_u2 = cyc;
        if (t_ana < 0 && ana_pwr_en_o) t_ana = cyc;
        if (t_pcs < 0 && pcs_pwr_ok_o) t_pcs = cyc;
        if (t_pma < 0 && pma_pwr_ok_o) t_pma = cyc;
        if (t_ssc < 0 && ssc_en_o) t_ssc = cyc;
        if (t_crel < 0 && ctrl_rst_n_o) t_crel = cyc;
        if (t_aux < 0 && aux_rst_n_o) t_aux = cyc;
        if (t_vb3 < 0 && u3_vbus_valid_o && u3_vbus_sel_o) t_vb3 = cyc;
        if (t_vb2 < 0 && u2_vbus_valid_o && u2_vbus_sel_o) t_vb2 = cyc;
        if (t_req < 0 && req_valid_o) t_req = cyc;
      end
    end
  end

  task automatic run_seq(bit pad, int rdt, bit wrt, logic [15:0] rv, bit poke);
    bit ok_exp;
    int n;
    rd_tmo_left = rdt; wr_tmo_cfg = wrt; rd_val = rv; n_rd = 0; n_wr = 0;
    {t_crst, t_clk, t_iddq, t_tpd, t_u3, t_u2, t_ana, t_pcs} = {8{32'hFFFF_FFFF}};
    {t_pma, t_ssc, t_crel, t_aux, t_vb3, t_vb2, t_req} = {7{32'hFFFF_FFFF}};
    arm = 1;
    clk_src_pad_i = pad; start_i = 1;
    @(negedge clk); start_i = 0;
    if (poke) begin
      n = 0;
      while (!u3phy_rst_n_o && n < 100) begin @(negedge clk); n++; end
      stop_i = 1; start_i = 1;
      @(negedge clk); stop_i = 0; start_i = 0;
      @(negedge clk);
      chk(u3phy_rst_n_o && refclk_en_o, "R10 stray stop/start mid-run",
          {u3phy_rst_n_o, refclk_en_o}, 3);
    end
    n = 0;
    while (!ready_o && !error_o && n < 2000) begin @(negedge clk); n++; end
    arm = 0;
    ok_exp = (rdt < 3) && !wrt;
    chk(ready_o == ok_exp, "R7 ready", ready_o, ok_exp);
    chk(error_o == !ok_exp, "R6/R7 error flag R6 R7", error_o, !ok_exp);
    chk(n_rd == ((rdt < 3) ? rdt + 1 : 3), "R6 read attempts", n_rd, (rdt < 3) ? rdt + 1 : 3);
    chk(n_wr == ((rdt < 3) ? 1 : 0), "R7 write count", n_wr, (rdt < 3) ? 1 : 0);
    if (rdt < 3) begin
      chk(wr_seen == exp_wdata(rv), "R7 write data", wr_seen, exp_wdata(rv));
      chk(addr_seen == 16'h000F, "R6 address", addr_seen, 16'h000F);
    end
    chk(refclk_pad_o == pad, "R2 clock source", refclk_pad_o, pad);
    chk(t_crst >= 0 && t_crst < t_clk, "R2 resets before clock", t_crst, t_clk);
    chk(t_iddq == t_clk + 1 && t_tpd == t_iddq + 1, "R3 iddq/testpd steps", t_tpd - t_clk, 2);
    chk(t_u3 == t_tpd + 1 && t_u2 == t_u3, "R3 phy reset release", t_u3 - t_tpd, 1);
    chk(t_ana - t_u3 == W, "R4 first wait", t_ana - t_u3, W);
    chk(t_pcs == t_ana && t_pma == t_ana, "R4 power-good together", t_pma, t_ana);
    chk(t_ssc > t_ana && t_crel > t_ssc && t_aux == t_crel, "R5 ssc then ctrl release",
        t_crel - t_ssc, 1);
    chk(t_vb3 - t_crel == W && t_vb2 == t_vb3, "R5 second wait", t_vb3 - t_crel, W);
    chk(t_req - t_vb3 == W, "R6 third wait", t_req - t_vb3, W);
  endtask

  task automatic shutdown;
    logic pre_crst;
    pre_crst = ctrl_rst_n_o;
    stop_i = 1; @(negedge clk); stop_i = 0;
    chk(!u3phy_rst_n_o && !u2por_n_o, "R9 phy resets asserted", {u3phy_rst_n_o, u2por_n_o}, 0);
    chk(!refclk_en_o && !ready_o && !error_o, "R9 clock off, flags clear",
        {refclk_en_o, ready_o, error_o}, 0);
    chk(ctrl_rst_n_o == pre_crst && !u2_iddq_o && ssc_en_o, "R9 others hold",
        {ctrl_rst_n_o, u2_iddq_o, ssc_en_o}, {pre_crst, 2'b01});
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({ctrl_rst_n_o, aux_rst_n_o, u3phy_rst_n_o, u2por_n_o} == 4'b0, "R1 resets",
        {ctrl_rst_n_o, aux_rst_n_o, u3phy_rst_n_o, u2por_n_o}, 0);
    chk(u2_iddq_o && u3_testpd_o, "R1 power-down", {u2_iddq_o, u3_testpd_o}, 3);
    chk({ana_pwr_en_o, ssc_en_o, u3_vbus_valid_o, u2_vbus_sel_o, refclk_en_o,
         ready_o, error_o, req_valid_o} == 8'b0, "R1 idle outputs",
        {ana_pwr_en_o, ssc_en_o, u3_vbus_valid_o, u2_vbus_sel_o, refclk_en_o,
         ready_o, error_o, req_valid_o}, 0);

    run_seq(0, 0, 0, 16'h1234, 0); shutdown();
    run_seq(1, 2, 0, 16'hFFFF, 1); shutdown();
    run_seq(0, 3, 0, 16'h0000, 0); shutdown();
    run_seq(1, 0, 1, 16'h8001, 0); shutdown();
    for (int i = 0; i < 6; i++) begin
      run_seq(1'($urandom), int'($urandom % 4), ($urandom % 4) == 0,
              16'($urandom), 1'($urandom));
      shutdown();
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule